// File: doc/BRIEF.md
# Pipelined GF(2^13) Field Multiplier

This block multiplies two elements of the binary field GF(2^13). Elements are held in polynomial basis: bit i of a 13-bit word is the coefficient of x^i. Every product is reduced modulo the fixed irreducible polynomial x^13+x^4+x^3+x^2+1. Field addition is bitwise XOR and bit multiplication is AND. Reduction therefore turns each x^13 term into the pattern 13'h001D.

The multiply is spread across four lanes that work in parallel. Lane j handles the bits of the second operand whose index is congruent to j modulo 4. Each lane is a short systolic chain of four stages. In every stage the lane's multiplicand is advanced by x^4 with reduction, ANDed with one operand bit, and XORed into a running partial sum. Lane 0 uses all four of its stages. The other lanes have only three operand bits, so their last stage is a plain delay that keeps the four partial sums aligned. The pipelined copy of the second operand is held once and read by all four lanes. A two-level registered XOR tree merges the four partial sums: two cells in the first level and one in the second.

A new operand pair may be presented on every clock. A valid flag travels with the data, and the product appears exactly six cycles later.

Top module: `gf13_sysmul`

## Requirements
- R1: When `vld_o` is high, `prod_o` equals opa·opb reduced modulo x^13+x^4+x^3+x^2+1, where opa and opb are the operands accepted with the matching `vld_i`. Bit i of each word is the coefficient of x^i.
- R2: An operand pair sampled with `vld_i` high at a rising edge produces `vld_o` high after exactly the sixth rising edge from that one, counting that edge as the first.
- R3: Operand pairs presented on consecutive cycles produce products on consecutive cycles, in the same order, with no stall.
- R4: While `rst` is high at a rising edge, all pipeline state is cleared. After that edge `vld_o` is 0 and `prod_o` is 13'h0000, and pairs accepted before the reset never emerge.
- R5: If either operand is 13'h0000, the product is 13'h0000.
- R6: If one operand is 13'h0001, the product equals the other operand.
- R7: Reduction folds x^13 into 13'h001D. For example, 13'h1000·13'h0002 = 13'h001D and 13'h1000·13'h0004 = 13'h003A.
- R8: A cycle with `vld_i` low produces `vld_o` low in the matching output cycle, even when it sits between valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Operand pair valid |
| opa_i | input | 13 | First operand, polynomial basis |
| opb_i | input | 13 | Second operand, polynomial basis |
| vld_o | output | 1 | Product valid |
| prod_o | output | 13 | Product, polynomial basis |

## Verification
The bench targets the reduction boundary with x^12 times x and x^12 times x^2. A design with a wrong fold pattern would return an unreduced or shifted value there, and the all-ones operands stress every fold at once. It checks identity and zero operands, which expose a lane whose operand bit is mapped to the wrong index or whose delay cell corrupts its partial sum. Back-to-back streams with idle gaps in between catch a valid flag that is off by a cycle or that lets a bubble through. A reset in the middle of a stream catches pipeline state that survives reset and emits stale products.

// File: rtl/gf13_sysmul.sv
module gf13_sysmul #(
  parameter int W = 13,
  parameter logic [W-1:0] RED = 13'h001D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         vld_o,
  output logic [W-1:0] prod_o
);
  localparam int LANES = 4;
  localparam int STG = (W + LANES - 1) / LANES;

  function automatic logic [W-1:0] mulx(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? RED : '0);
  endfunction

  function automatic logic [W-1:0] xpow(input logic [W-1:0] v, input int n);
    logic [W-1:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = mulx(r);
    return r;
  endfunction

  logic [W-1:0] ap_q  [STG-1][LANES];
  logic [W-1:0] acc_q [STG][LANES];
  logic [W-1:0] b_q   [STG-1];
  logic         v_q   [STG];

  for (genvar k = 0; k < STG; k++) begin : g_stg
    logic [W-1:0] bsrc;
    logic         vsrc;
    if (k == 0) begin : g_in
      assign bsrc = opb_i;
      assign vsrc = vld_i;
    end else begin : g_mid
      assign bsrc = b_q[k-1];
      assign vsrc = v_q[k-1];
    end

    always_ff @(posedge clk)
      if (rst) v_q[k] <= 1'b0;
      else     v_q[k] <= vsrc;

    if (k < STG - 1) begin : g_bpipe
      always_ff @(posedge clk)
        if (rst) b_q[k] <= '0;
        else     b_q[k] <= bsrc;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam int BIT = LANES * k + j;
      logic [W-1:0] ap_d, acc_d, acc_n;
      if (k == 0) begin : g_src0
        assign ap_d  = xpow(opa_i, j);
        assign acc_d = '0;
      end else begin : g_srcn
        assign ap_d  = ap_q[k-1][j];
        assign acc_d = acc_q[k-1][j];
      end

      if (BIT < W) begin : g_pe
        assign acc_n = acc_d ^ (bsrc[BIT] ? ap_d : '0);
      end else begin : g_dly
        assign acc_n = acc_d;
      end

      always_ff @(posedge clk)
        if (rst) acc_q[k][j] <= '0;
        else     acc_q[k][j] <= acc_n;

      if (k < STG - 1) begin : g_adv
        always_ff @(posedge clk)
          if (rst) ap_q[k][j] <= '0;
          else     ap_q[k][j] <= xpow(ap_d, LANES);
      end
    end
  end

  logic [W-1:0] t0_q, t1_q;
  logic         tv_q;

  always_ff @(posedge clk)
    if (rst) begin
      t0_q   <= '0;
      t1_q   <= '0;
      tv_q   <= 1'b0;
      prod_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      t0_q   <= acc_q[STG-1][0] ^ acc_q[STG-1][1];
      t1_q   <= acc_q[STG-1][2] ^ acc_q[STG-1][3];
      tv_q   <= v_q[STG-1];
      prod_o <= t0_q ^ t1_q;
      vld_o  <= tv_q;
    end
endmodule

// File: rtl/gf13_sysmul_chk.sv
module gf13_sysmul_chk #(
  parameter int W = 13,
  parameter logic [W-1:0] RED = 13'h001D
) (
  input logic         clk,
  input logic         rst,
  input logic         vld_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         vld_o,
  input logic [W-1:0] prod_o
);
  localparam int LAT = (W + 3) / 4 + 2;

  function automatic logic [W-1:0] refmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r, s;
    r = '0;
    s = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[W-2:0], 1'b0} ^ (s[W-1] ? RED : '0);
    end
    return r;
  endfunction

  logic [W-1:0] ha [LAT];
  logic [W-1:0] hb [LAT];
  logic         hv [LAT];

  always_ff @(posedge clk)
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        ha[i] <= '0; hb[i] <= '0; hv[i] <= 1'b0;
      end
    end else begin
      ha[0] <= opa_i; hb[0] <= opb_i; hv[0] <= vld_i;
      for (int i = 1; i < LAT; i++) begin
        ha[i] <= ha[i-1]; hb[i] <= hb[i-1]; hv[i] <= hv[i-1];
      end
    end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    vld_o == hv[LAT-1]);
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> prod_o == refmul(ha[LAT-1], hb[LAT-1]));
  a_r6_identity: assert property (@(posedge clk) disable iff (rst)
    (vld_o && hb[LAT-1] == 13'h0001) |-> prod_o == ha[LAT-1]);
  a_r5_zero: assert property (@(posedge clk) disable iff (rst)
    (vld_o && (ha[LAT-1] == '0 || hb[LAT-1] == '0)) |-> prod_o == '0);
  a_r4_reset: assert property (@(posedge clk)
    $past(rst) |-> (!vld_o && prod_o == '0));
endmodule

bind gf13_sysmul gf13_sysmul_chk #(.W(W), .RED(RED)) u_chk (.*);

// File: tb/sim_gf13_sysmul.sv
`timescale 1ns/1ps
module sim_gf13_sysmul;
  localparam int W = 13;
  localparam int LAT = 6;
  localparam int NV = 16;
  localparam logic [W-1:0] RED = 13'h001D;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 13'h1000, 13'h0002}, {1'b1, 13'h1000, 13'h0004},
    {1'b1, 13'h1FFF, 13'h1FFF}, {1'b1, 13'h0000, 13'h1ABC},
    {1'b1, 13'h0F0F, 13'h0000}, {1'b0, 13'h1234, 13'h0567},
    {1'b1, 13'h0001, 13'h1357}, {1'b1, 13'h1BAD, 13'h0001},
    {1'b1, 13'h0ACE, 13'h1CAB}, {1'b0, 13'h1111, 13'h1111},
    {1'b0, 13'h0222, 13'h0333}, {1'b1, 13'h1FFF, 13'h0001},
    {1'b1, 13'h0F00, 13'h00F0}, {1'b1, 13'h1555, 13'h0AAA},
    {1'b1, 13'h0002, 13'h1000}, {1'b1, 13'h1FFF, 13'h0800}
  };

  logic clk = 1'b0, rst = 1'b1, vld_i = 1'b0;
  logic [W-1:0] opa_i = '0, opb_i = '0;
  logic vld_o;
  logic [W-1:0] prod_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic         hv [LAT];
  logic [W-1:0] hp [LAT];
  string        ht [LAT];

  always #5 clk = ~clk;

  gf13_sysmul u0 (.clk(clk), .rst(rst), .vld_i(vld_i), .opa_i(opa_i),
                  .opb_i(opb_i), .vld_o(vld_o), .prod_o(prod_o));

  function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = {r[W-2:0], 1'b0} ^ (r[W-1] ? RED : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < LAT; i++) begin
      hv[i] = 1'b0; hp[i] = '0; ht[i] = "R8";
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input string tag, input logic use_exp, input logic [W-1:0] xexp);
    @(negedge clk);
    check({ht[LAT-1], " valid"}, {12'd0, vld_o}, {12'd0, hv[LAT-1]});
    if (hv[LAT-1]) check({ht[LAT-1], " product"}, prod_o, hp[LAT-1]);
    for (int i = LAT - 1; i > 0; i--) begin
      hv[i] = hv[i-1]; hp[i] = hp[i-1]; ht[i] = ht[i-1];
    end
    hv[0] = v;
    hp[0] = use_exp ? xexp : gmul(a, b);
    ht[0] = v ? tag : "R8";
    vld_i = v; opa_i = a; opb_i = b;
  endtask

  initial begin
    #(200000 * 10);
    nfail++; nchk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    clear_hist();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset valid", {12'd0, vld_o}, 13'd0);
    check("R4 reset product", prod_o, 13'd0);
    rst = 1'b0;

    // R1 R3 R8: table streamed back to back with idle gaps
    for (int i = 0; i < NV; i++)
      step(VEC[i][26], VEC[i][25:13], VEC[i][12:0], "R1/R3", 1'b0, '0);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, "R8", 1'b0, '0);

    // R7: hand-computed reductions
    step(1'b1, 13'h1000, 13'h0002, "R7 x12*x", 1'b1, 13'h001D);
    step(1'b1, 13'h1000, 13'h0004, "R7 x12*x2", 1'b1, 13'h003A);
    // R5 / R6 with fixed expectations
    step(1'b1, 13'h1FFF, 13'h0000, "R5 zero", 1'b1, 13'h0000);
    step(1'b1, 13'h0001, 13'h1FFF, "R6 identity", 1'b1, 13'h1FFF);
    step(1'b1, 13'h0B6D, 13'h0001, "R6 identity", 1'b1, 13'h0B6D);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, "R8", 1'b0, '0);

    // R2: single pulse, exact arrival cycle
    step(1'b1, 13'h0123, 13'h1456, "R2 single", 1'b0, '0);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, "R2 idle", 1'b0, '0);

    // R4: reset mid-stream drops in-flight work
    for (int i = 0; i < 4; i++) step(1'b1, 13'(i * 397 + 5), 13'(i * 811 + 3), "R3", 1'b0, '0);
    @(negedge clk);
    rst = 1'b1; vld_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R4 mid valid", {12'd0, vld_o}, 13'd0);
    check("R4 mid product", prod_o, 13'd0);
    clear_hist();
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, "R4 flushed", 1'b0, '0);

    // R1 R3: long back-to-back sweep
    for (int i = 0; i < 200; i++)
      step(1'b1, 13'(i * 4513 + 77), 13'(i * 2897 + 1031), "R1 sweep", 1'b0, '0);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, "R8", 1'b0, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule